// File: doc/BRIEF.md
# Battery-Backed Real-Time Clock Register Controller

This block is the digital core of a real-time clock that lives in an always-on, battery-fed power domain. A 32.768 kHz clock-enable drives a prescaler, and each full turn of the prescaler advances a 32-bit seconds count. Software reaches the clock through a small single-cycle register bus. That bus holds the two time values, a control word with an oscillator-enable bit and a self-sticky soft-reset bit, a status word with the count-enable bit, and a permission word that sits outside the battery domain.

Each request is judged on its own. Requests to the clock registers get an error response while the battery supply is missing, while the domain is isolated, or while the battery power-on reset is active. When the permission word forbids it, writes issued from user (non-supervisor) mode also get an error response. Requests that receive an error change nothing. The bus applies no back-pressure: the block takes every request in the cycle it is presented and always answers exactly one cycle later. It therefore has no ready signal, and the requester never has to stall.

There are three reset sources. The main chip reset clears only the permission word and the bus response stage. The battery power-on reset clears every clock register. The soft-reset bit holds the clock registers cleared while it is set, but it never clears itself or the permission word.

Top module: `rtc_bat_ctrl`

## Requirements
- R1: A request with `req_valid` high in one cycle produces `resp_valid` high in the next cycle and in no other cycle. Write responses and error responses carry `resp_rdata` = 0.
- R2: While status bit 0 (count enable, offset 0x14) is set, each cycle with `tick_32k` high advances the prescaler (offset 0x4) modulo `PRESC_MOD`. When the prescaler wraps to 0, the seconds count (offset 0x0) increments, and it wraps from 0xFFFFFFFF to 0.
- R3: While count enable is clear, `tick_32k` has no effect on the prescaler or the seconds count.
- R4: Writes to 0x0 or 0x4 take effect only while count enable is clear. While it is set they are dropped without an error. A prescaler write keeps only the low log2(`PRESC_MOD`) bits of the data.
- R5: Writing 1 to control bit 0 (offset 0x10) clears the seconds count, the prescaler, control bit 1 and the status word from the next cycle on, and holds them clear. The bit itself and the permission word keep their values, and the bit stays set until software writes 0 to it.
- R6: Control bit 1 drives `osc_en`. It reads 0 after a battery power-on reset.
- R7: A request to 0x0, 0x4, 0x10 or 0x14 while `vbat_ok` is low, `isolated` is high or `vbat_por` is high gets an error response and modifies nothing. The permission word at 0x800 stays reachable under these conditions.
- R8: While permission bit 0 (offset 0x800) is clear, a write with `req_super` low to any mapped offset gets an error response and changes nothing. When the bit is set, such writes proceed. Reads never fail for lack of supervisor mode.
- R9: The permission word resets to 0 only on `chip_rst_n`. The battery power-on reset clears all clock registers and leaves the permission word unchanged. A chip reset leaves the clock registers unchanged.
- R10: A request to an unmapped offset returns `resp_rdata` = 0 with no error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| chip_rst_n | input | 1 | Main chip reset, active low, asynchronous |
| vbat_por | input | 1 | Battery-domain power-on reset, active high, asynchronous |
| vbat_ok | input | 1 | Battery supply present |
| isolated | input | 1 | Battery domain isolated from the core |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz period |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| req_super | input | 1 | Request issued from supervisor mode |
| resp_valid | output | 1 | Response present |
| resp_rdata | output | 32 | Read data |
| resp_err | output | 1 | Request was refused |
| osc_en | output | 1 | Oscillator enable from control bit 1 |

## Verification
The bench builds the block with `PRESC_MOD` = 16, which makes a second only 16 ticks long. With that setting, prescaler wrap, the seconds carry and the 0xFFFFFFFF-to-0 rollover can all be reached in a handful of cycles by preloading the counters. `ADDR_W` stays at 12 so that the 0x800 permission word and the unmapped offsets keep their full-width decode.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam logic [11:0] OFS_SEC   = 12'h000;
  localparam logic [11:0] OFS_PRESC = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h010;
  localparam logic [11:0] OFS_STAT  = 12'h014;
  localparam logic [11:0] OFS_PERM  = 12'h800;

  typedef struct packed {
    logic sec;
    logic presc;
    logic ctrl;
    logic stat;
    logic perm;
  } rtc_hit_t;
endpackage

// File: rtl/rtc_access_gate.sv
module rtc_access_gate #(
  parameter int ADDR_W = 12
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_super,
  input  logic              vbat_ok,
  input  logic              isolated,
  input  logic              vbat_por,
  input  logic              user_wr_ok,
  output rtc_pkg::rtc_hit_t hit,
  output logic              refuse,
  output logic              wr_go
);
  import rtc_pkg::*;

  logic batt_reg, mapped, power_bad, priv_bad;

  always_comb begin
    hit.sec   = (req_addr == ADDR_W'(OFS_SEC));
    hit.presc = (req_addr == ADDR_W'(OFS_PRESC));
    hit.ctrl  = (req_addr == ADDR_W'(OFS_CTRL));
    hit.stat  = (req_addr == ADDR_W'(OFS_STAT));
    hit.perm  = (req_addr == ADDR_W'(OFS_PERM));
  end

  assign batt_reg  = hit.sec | hit.presc | hit.ctrl | hit.stat;
  assign mapped    = batt_reg | hit.perm;
  assign power_bad = batt_reg & (!vbat_ok | isolated | vbat_por);
  assign priv_bad  = req_write & mapped & !req_super & !user_wr_ok;
  assign refuse    = req_valid & (power_bad | priv_bad);
  assign wr_go     = req_valid & req_write & !refuse;
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
  parameter int SEC_W     = 32,
  parameter int PRESC_W   = 16,
  parameter int PRESC_MOD = 32768
) (
  input  logic               clk,
  input  logic               vbat_por,
  input  logic               soft_clr,
  input  logic               run,
  input  logic               tick,
  input  logic               ld_sec,
  input  logic               ld_presc,
  input  logic [SEC_W-1:0]   wdata,
  output logic [SEC_W-1:0]   sec_q,
  output logic [PRESC_W-1:0] presc_q
);
  localparam int CNT_W = $clog2(PRESC_MOD);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRESC_MOD - 1);

  logic [CNT_W-1:0] cnt;
  logic             step, carry;

  assign step  = run & tick;
  assign carry = step & (cnt == CNT_TOP);

  always_ff @(posedge clk or posedge vbat_por) begin
    if (vbat_por) begin
      cnt   <= '0;
      sec_q <= '0;
    end else if (soft_clr) begin
      cnt   <= '0;
      sec_q <= '0;
    end else begin
      if (ld_presc && !run)  cnt <= wdata[CNT_W-1:0];
      else if (carry)        cnt <= '0;
      else if (step)         cnt <= cnt + 1'b1;
      if (ld_sec && !run)    sec_q <= wdata;
      else if (carry)        sec_q <= sec_q + 1'b1;
    end
  end

  assign presc_q = PRESC_W'(cnt);
endmodule

// File: rtl/rtc_bat_ctrl.sv
module rtc_bat_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int PRESC_W   = 16,
  parameter int PRESC_MOD = 32768
) (
  input  logic              clk,
  input  logic              chip_rst_n,
  input  logic              vbat_por,
  input  logic              vbat_ok,
  input  logic              isolated,
  input  logic              tick_32k,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_super,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              resp_err,
  output logic              osc_en
);
  import rtc_pkg::*;

  rtc_hit_t          hit;
  logic              refuse, wr_go;
  logic              soft_rst, osc_on, count_en, user_wr_ok;
  logic [DATA_W-1:0] sec_q;
  logic [PRESC_W-1:0] presc_q;
  logic [DATA_W-1:0] rd_mux;

  rtc_access_gate #(.ADDR_W(ADDR_W)) u_gate (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_super (req_super),
    .vbat_ok   (vbat_ok),
    .isolated  (isolated),
    .vbat_por  (vbat_por),
    .user_wr_ok(user_wr_ok),
    .hit       (hit),
    .refuse    (refuse),
    .wr_go     (wr_go)
  );

  rtc_time_counter #(
    .SEC_W    (DATA_W),
    .PRESC_W  (PRESC_W),
    .PRESC_MOD(PRESC_MOD)
  ) u_time (
    .clk     (clk),
    .vbat_por(vbat_por),
    .soft_clr(soft_rst),
    .run     (count_en),
    .tick    (tick_32k),
    .ld_sec  (wr_go & hit.sec),
    .ld_presc(wr_go & hit.presc),
    .wdata   (req_wdata),
    .sec_q   (sec_q),
    .presc_q (presc_q)
  );

  // soft-reset bit: cleared only by battery POR or by software
  always_ff @(posedge clk or posedge vbat_por) begin
    if (vbat_por)                soft_rst <= 1'b0;
    else if (wr_go && hit.ctrl)  soft_rst <= req_wdata[0];
  end

  // battery-domain control/status cleared by POR or soft reset
  always_ff @(posedge clk or posedge vbat_por) begin
    if (vbat_por) begin
      osc_on   <= 1'b0;
      count_en <= 1'b0;
    end else if (soft_rst) begin
      osc_on   <= 1'b0;
      count_en <= 1'b0;
    end else begin
      if (wr_go && hit.ctrl) osc_on   <= req_wdata[1];
      if (wr_go && hit.stat) count_en <= req_wdata[0];
    end
  end

  // permission word lives in the chip reset domain
  always_ff @(posedge clk or negedge chip_rst_n) begin
    if (!chip_rst_n)             user_wr_ok <= 1'b0;
    else if (wr_go && hit.perm)  user_wr_ok <= req_wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    if (hit.sec)   rd_mux = sec_q;
    if (hit.presc) rd_mux = DATA_W'(presc_q);
    if (hit.ctrl)  rd_mux = {{(DATA_W-2){1'b0}}, osc_on, soft_rst};
    if (hit.stat)  rd_mux = {{(DATA_W-1){1'b0}}, count_en};
    if (hit.perm)  rd_mux = {{(DATA_W-1){1'b0}}, user_wr_ok};
  end

  always_ff @(posedge clk or negedge chip_rst_n) begin
    if (!chip_rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= refuse;
      resp_rdata <= (req_valid && !req_write && !refuse) ? rd_mux : '0;
    end
  end

  assign osc_en = osc_on;
endmodule

// File: rtl/rtc_bat_ctrl_chk.sv
module rtc_bat_ctrl_chk #(
  parameter int ADDR_W    = 12,
  parameter int PRESC_W   = 16,
  parameter int PRESC_MOD = 32768
) (
  input logic               clk,
  input logic               chip_rst_n,
  input logic               vbat_por,
  input logic               vbat_ok,
  input logic               isolated,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               req_super,
  input logic               resp_valid,
  input logic [31:0]        resp_rdata,
  input logic               resp_err,
  input logic               user_wr_ok,
  input logic               count_en,
  input logic               soft_rst,
  input logic [31:0]        sec_q,
  input logic [PRESC_W-1:0] presc_q
);
  assert_resp_next_R1: assert property (@(posedge clk) disable iff (!chip_rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!chip_rst_n)
    !req_valid |=> !resp_valid);

  assert_err_zero_R1: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (resp_valid && resp_err) |-> (resp_rdata == 32'd0));

  assert_presc_range_R2: assert property (@(posedge clk) disable iff (!chip_rst_n || vbat_por)
    PRESC_W'(presc_q) < PRESC_W'(PRESC_MOD));

  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!chip_rst_n || vbat_por)
    (!count_en && !req_valid && !soft_rst) |=> $stable(sec_q) && $stable(presc_q));

  assert_power_gate_R7: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (req_valid && req_addr == '0 && (isolated || vbat_por || !vbat_ok)) |=> resp_err);

  assert_user_write_R8: assert property (@(posedge clk) disable iff (!chip_rst_n)
    (req_valid && req_write && !req_super && !user_wr_ok && req_addr == '0) |=> resp_err);
endmodule

bind rtc_bat_ctrl rtc_bat_ctrl_chk #(
  .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .PRESC_MOD(PRESC_MOD)
) u_chk (
  .clk(clk), .chip_rst_n(chip_rst_n), .vbat_por(vbat_por), .vbat_ok(vbat_ok),
  .isolated(isolated), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_super(req_super), .resp_valid(resp_valid),
  .resp_rdata(resp_rdata), .resp_err(resp_err), .user_wr_ok(user_wr_ok),
  .count_en(count_en), .soft_rst(soft_rst), .sec_q(sec_q), .presc_q(presc_q)
);

// File: tb/sim_rtc_bat_ctrl.sv
module sim_rtc_bat_ctrl;
  localparam int ADDR_W = 12;
  localparam int PMOD   = 16;

  logic clk = 1'b0;
  logic chip_rst_n, vbat_por, vbat_ok, isolated, tick_32k;
  logic req_valid, req_write, req_super;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0] req_wdata;
  logic resp_valid, resp_err, osc_en;
  logic [31:0] resp_rdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  rtc_bat_ctrl #(.ADDR_W(ADDR_W), .PRESC_W(16), .PRESC_MOD(PMOD)) u0 (
    .clk(clk), .chip_rst_n(chip_rst_n), .vbat_por(vbat_por), .vbat_ok(vbat_ok),
    .isolated(isolated), .tick_32k(tick_32k), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_super(req_super), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_err(resp_err), .osc_en(osc_en)
  );

  // monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (resp_valid) begin
      compared++;
      if (sb.size() == 0) begin
        mismatched++;
        $display("FAIL R1: response with nothing expected, data=%h err=%b", resp_rdata, resp_err);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (resp_rdata !== e.data || resp_err !== e.err) begin
          mismatched++;
          $display("FAIL %s: got data=%h err=%b, expected data=%h err=%b",
                   e.tag, resp_rdata, resp_err, e.data, e.err);
        end
      end
    end
  end

  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input bit sup, input logic [31:0] ed, input bit ee, input string tag);
    exp_t e;
    e.data = ed; e.err = ee; e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_super = sup;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string tag);
    xfer(1'b1, a, d, 1'b1, 32'd0, 1'b0, tag);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] ed, input string tag);
    xfer(1'b0, a, 32'd0, 1'b1, ed, 1'b0, tag);
  endtask

  task automatic ticks(input int n);
    tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    chip_rst_n = 1'b0; vbat_por = 1'b1; vbat_ok = 1'b1; isolated = 1'b0; tick_32k = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_super = 1'b0;
    repeat (4) @(negedge clk);
    chip_rst_n = 1'b1;
    chk("R1 idle", {31'd0, resp_valid}, 32'd0);
    // battery POR still active
    xfer(1'b0, 12'h000, 0, 1'b1, 0, 1'b1, "R7 por read");
    rd(12'h800, 0, "R9 perm reset");
    vbat_por = 1'b0;
    rd(12'h000, 0, "R9 sec reset");
    rd(12'h004, 0, "R9 presc reset");
    rd(12'h010, 0, "R6 ctrl reset");
    rd(12'h014, 0, "R9 stat reset");
    chk("R6 osc_en reset", {31'd0, osc_en}, 0);

    // supervisor write gate
    xfer(1'b1, 12'h000, 5, 1'b0, 0, 1'b1, "R8 user write refused");
    rd(12'h000, 0, "R8 unchanged");
    xfer(1'b1, 12'h800, 1, 1'b0, 0, 1'b1, "R8 user perm write refused");
    wr(12'h800, 1, "R8 super perm write");
    xfer(1'b1, 12'h000, 5, 1'b0, 0, 1'b0, "R8 user write allowed");
    xfer(1'b0, 12'h000, 0, 1'b0, 5, 1'b0, "R8 user read");

    // prescaler load masking
    wr(12'h004, 32'h3E, "R4 presc load");
    rd(12'h004, 32'hE, "R4 presc masked");

    // counting and carry
    wr(12'h014, 1, "R2 enable");
    ticks(2);
    rd(12'h004, 0, "R2 presc wrap");
    rd(12'h000, 6, "R2 seconds carry");
    wr(12'h000, 100, "R4 write while running");
    rd(12'h000, 6, "R4 dropped write");
    ticks(5);
    rd(12'h004, 5, "R2 presc count");

    // stopped
    wr(12'h014, 0, "R3 disable");
    ticks(3);
    rd(12'h004, 5, "R3 presc held");
    rd(12'h000, 6, "R3 seconds held");

    // seconds rollover
    wr(12'h000, 32'hFFFF_FFFF, "R2 preload sec");
    wr(12'h004, 15, "R2 preload presc");
    wr(12'h014, 1, "R2 enable");
    ticks(1);
    rd(12'h000, 0, "R2 seconds rollover");
    rd(12'h004, 0, "R2 presc after rollover");
    wr(12'h014, 0, "R2 disable");

    // oscillator enable and soft reset
    wr(12'h000, 7, "R5 preload");
    wr(12'h010, 2, "R6 osc on");
    chk("R6 osc_en set", {31'd0, osc_en}, 1);
    rd(12'h010, 2, "R6 ctrl readback");
    wr(12'h014, 1, "R5 enable");
    wr(12'h010, 1, "R5 soft reset");
    @(negedge clk);
    rd(12'h010, 1, "R5 bit sticks");
    rd(12'h000, 0, "R5 seconds cleared");
    rd(12'h014, 0, "R5 status cleared");
    rd(12'h800, 1, "R5 perm kept");
    chk("R5 osc cleared", {31'd0, osc_en}, 0);
    wr(12'h000, 9, "R5 write held");
    rd(12'h000, 0, "R5 still clear");
    wr(12'h010, 0, "R5 release");
    rd(12'h010, 0, "R5 bit cleared");
    wr(12'h000, 9, "R5 write after release");
    rd(12'h000, 9, "R5 value");

    // power / isolation gate
    isolated = 1'b1;
    xfer(1'b0, 12'h004, 0, 1'b1, 0, 1'b1, "R7 iso read");
    xfer(1'b1, 12'h000, 3, 1'b1, 0, 1'b1, "R7 iso write");
    rd(12'h800, 1, "R7 perm reachable");
    isolated = 1'b0;
    rd(12'h000, 9, "R7 no change");
    vbat_ok = 1'b0;
    xfer(1'b0, 12'h014, 0, 1'b1, 0, 1'b1, "R7 supply down");
    vbat_ok = 1'b1;

    // unmapped
    rd(12'h040, 0, "R10 unmapped read");
    wr(12'h044, 5, "R10 unmapped write");
    rd(12'h044, 0, "R10 unmapped stays zero");

    // reset domains
    chip_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chip_rst_n = 1'b1;
    rd(12'h800, 0, "R9 chip reset perm");
    rd(12'h000, 9, "R9 chip reset keeps sec");
    wr(12'h800, 1, "R9 perm set");
    vbat_por = 1'b1;
    @(negedge clk);
    vbat_por = 1'b0;
    rd(12'h800, 1, "R9 por keeps perm");
    rd(12'h000, 0, "R9 por clears sec");

    repeat (3) @(negedge clk);
    chk("R1 idle end", {31'd0, resp_valid}, 0);
    if (sb.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R1: %0d responses missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule